// File: doc/BRIEF.md
# Shared Write-Address Channel ID Tagger and Response Router

This block lets three write requesters share one AXI write-address (AW) channel: a write buffer, a flush controller and an uncached-access controller. A round-robin arbiter picks one pending request. The block then stamps the outgoing AW beat with a transaction ID that records which requester sent it and, for the two requesters that keep several outstanding entries, which entry it was.

On the return path the block reads the ID of each write response (B) beat. It raises a response strobe toward exactly one requester and supplies the entry index taken from the low ID bits. The ID scheme reserves the all-ones value for uncached traffic. The flush entry count is therefore limited so that no flush ID can be all ones, and a parameter set that breaks this limit stops elaboration.

A requester keeps its request, entry and address steady until it sees its grant pulse. The grant pulse marks the cycle in which the AW handshake completes.

Top module: `awtag_wr_id_mux`

## Requirements
- R1: Out of reset, with no request pending, `aw_valid` and all three grants are low, and all three response strobes are low while `b_valid` is low. The first arbitration after reset prefers the write buffer.
- R2: A write-buffer beat carries `aw_id` = {1'b0, `wb_entry`}.
- R3: A flush beat carries `aw_id` = {1'b1, `fl_entry`}.
- R4: An uncached beat carries `aw_id` with every bit set.
- R5: `aw_addr` equals the address of the selected requester. That requester's grant is high exactly in the cycle where `aw_valid` and `aw_ready` are both high.
- R6: Preference rotates in the order write buffer, flush, uncached, write buffer. After a completed handshake, the requester that follows the last winner in this order is tried first.
- R7: While `aw_valid` is high and `aw_ready` is low, the selected requester stays selected and its ID stays on `aw_id`, even when a requester with higher preference starts requesting.
- R8: A response whose ID MSB is 0 raises only `wb_b_valid`, and `b_entry` equals the low ID bits.
- R9: A response whose ID is all ones raises only `uc_b_valid`.
- R10: A response whose ID MSB is 1 and which is not all ones raises only `fl_b_valid`, and `b_entry` equals the low ID bits.
- R11: Response routing is combinational and independent of the AW side. With `b_valid` low no strobe rises, and a B beat that arrives in the same cycle as an AW handshake is routed correctly.
- R12: Elaboration fails if `FL_ENTRIES` exceeds 2^(ID_W-1)-1 or `WB_ENTRIES` exceeds 2^(ID_W-1). Counts that are not a power of two are accepted, and the highest flush entry round-trips to the flush requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wb_req | input | 1 | Write buffer requests the AW channel |
| wb_entry | input | ID_W-1 | Write buffer entry index |
| wb_addr | input | ADDR_W | Write buffer address |
| wb_gnt | output | 1 | Write buffer AW handshake done |
| fl_req | input | 1 | Flush controller requests the AW channel |
| fl_entry | input | ID_W-1 | Flush entry index |
| fl_addr | input | ADDR_W | Flush address |
| fl_gnt | output | 1 | Flush AW handshake done |
| uc_req | input | 1 | Uncached controller requests the AW channel |
| uc_addr | input | ADDR_W | Uncached address |
| uc_gnt | output | 1 | Uncached AW handshake done |
| aw_valid | output | 1 | AW valid |
| aw_ready | input | 1 | AW ready |
| aw_id | output | ID_W | AW transaction ID |
| aw_addr | output | ADDR_W | AW address |
| b_valid | input | 1 | B valid |
| b_id | input | ID_W | B transaction ID |
| wb_b_valid | output | 1 | Response belongs to the write buffer |
| fl_b_valid | output | 1 | Response belongs to the flush controller |
| uc_b_valid | output | 1 | Response belongs to the uncached controller |
| b_entry | output | ID_W-1 | Entry index decoded from the response ID |

## Verification
An AW handshake and a B response can land in the same cycle, because the two paths share nothing but the ID encoding. The bench completes a flush handshake while it presents a write-buffer response ID on the B side in that same cycle. It expects the flush grant and the ID {1, entry} on `aw_id`, and at the same time only the write-buffer strobe with the right entry. A second overlap comes from arbitration against a stalled `aw_ready`: a higher-preference request arrives while a stalled beat is pending. The bench expects the pending ID to stay in place until the handshake completes, and the newcomer to win only afterwards.

// File: rtl/awtag_pkg.sv
package awtag_pkg;

   typedef enum logic [1:0] {
      SRC_WB = 2'd0,
      SRC_FL = 2'd1,
      SRC_UC = 2'd2
   } src_e;

   localparam int unsigned NUM_SRC = 3;

   function automatic src_e next_src(input src_e s, input int unsigned step);
      return src_e'(2'((int'(s) + int'(step)) % NUM_SRC));
   endfunction

endpackage

// File: rtl/awtag_rr_arb.sv
module awtag_rr_arb
   import awtag_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] req_i,
   input  logic       ready_i,
   output logic       valid_o,
   output src_e       sel_o,
   output logic [2:0] gnt_o
);

   src_e last_q;
   src_e own_q;
   logic lock_q;
   src_e pick;

   always_comb begin
      pick = next_src(last_q, 1);
      for (int k = NUM_SRC; k >= 1; k--) begin
         if (req_i[next_src(last_q, k)]) pick = next_src(last_q, k);
      end
   end

   assign sel_o   = lock_q ? own_q : pick;
   assign valid_o = lock_q ? req_i[own_q] : (|req_i);

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_gnt
      assign gnt_o[g] = valid_o && ready_i && (sel_o == src_e'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= SRC_UC;
         own_q  <= SRC_WB;
         lock_q <= 1'b0;
      end else if (valid_o && ready_i) begin
         last_q <= sel_o;
         lock_q <= 1'b0;
      end else if (valid_o) begin
         own_q  <= sel_o;
         lock_q <= 1'b1;
      end
   end

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o)); // R5
   AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      |gnt_o |-> |(gnt_o & req_i)); // R5
   AST_HOLD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !ready_i |=> sel_o == $past(sel_o)); // R7

endmodule

// File: rtl/awtag_b_route.sv
module awtag_b_route #(
   parameter int unsigned ID_W = 4,
   localparam int unsigned IDX_W = ID_W - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             b_valid_i,
   input  logic [ID_W-1:0]  b_id_i,
   output logic             wb_o,
   output logic             fl_o,
   output logic             uc_o,
   output logic [IDX_W-1:0] entry_o
);

   logic top_bit;
   logic all_set;

   assign top_bit = b_id_i[ID_W-1];
   assign all_set = &b_id_i;
   assign wb_o    = b_valid_i && !top_bit;
   assign uc_o    = b_valid_i && all_set;
   assign fl_o    = b_valid_i && top_bit && !all_set;
   assign entry_o = b_id_i[IDX_W-1:0];

   AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      b_valid_i |-> $countones({wb_o, fl_o, uc_o}) == 1); // R8
   AST_NO_ROUTE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !b_valid_i |-> !(wb_o || fl_o || uc_o)); // R11

endmodule

// File: rtl/awtag_wr_id_mux.sv
module awtag_wr_id_mux
   import awtag_pkg::*;
#(
   parameter int unsigned ID_W       = 4,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned WB_ENTRIES = 8,
   parameter int unsigned FL_ENTRIES = 7,
   localparam int unsigned IDX_W     = ID_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wb_req,
   input  logic [IDX_W-1:0]  wb_entry,
   input  logic [ADDR_W-1:0] wb_addr,
   output logic              wb_gnt,
   input  logic              fl_req,
   input  logic [IDX_W-1:0]  fl_entry,
   input  logic [ADDR_W-1:0] fl_addr,
   output logic              fl_gnt,
   input  logic              uc_req,
   input  logic [ADDR_W-1:0] uc_addr,
   output logic              uc_gnt,
   output logic              aw_valid,
   input  logic              aw_ready,
   output logic [ID_W-1:0]   aw_id,
   output logic [ADDR_W-1:0] aw_addr,
   input  logic              b_valid,
   input  logic [ID_W-1:0]   b_id,
   output logic              wb_b_valid,
   output logic              fl_b_valid,
   output logic              uc_b_valid,
   output logic [IDX_W-1:0]  b_entry
);

   localparam int unsigned HALF_SPACE = 1 << IDX_W;

   if (ID_W < 2) begin : g_bad_id
      $error("ID_W must be at least 2");
   end
   if (FL_ENTRIES == 0 || FL_ENTRIES > HALF_SPACE - 1) begin : g_bad_fl
      $error("FL_ENTRIES must be 1..2**(ID_W-1)-1 so no flush ID is all ones"); // R12
   end
   if (WB_ENTRIES == 0 || WB_ENTRIES > HALF_SPACE) begin : g_bad_wb
      $error("WB_ENTRIES must be 1..2**(ID_W-1)"); // R12
   end

   src_e       sel;
   logic [2:0] gnt;

   awtag_rr_arb u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   ({uc_req, fl_req, wb_req}),
      .ready_i (aw_ready),
      .valid_o (aw_valid),
      .sel_o   (sel),
      .gnt_o   (gnt)
   );

   assign wb_gnt = gnt[SRC_WB];
   assign fl_gnt = gnt[SRC_FL];
   assign uc_gnt = gnt[SRC_UC];

   always_comb begin
      unique case (sel)
         SRC_WB: begin
            aw_id   = {1'b0, wb_entry};
            aw_addr = wb_addr;
         end
         SRC_FL: begin
            aw_id   = {1'b1, fl_entry};
            aw_addr = fl_addr;
         end
         default: begin
            aw_id   = '1;
            aw_addr = uc_addr;
         end
      endcase
   end

   awtag_b_route #(.ID_W(ID_W)) u_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .b_valid_i (b_valid),
      .b_id_i    (b_id),
      .wb_o      (wb_b_valid),
      .fl_o      (fl_b_valid),
      .uc_o      (uc_b_valid),
      .entry_o   (b_entry)
   );

   AST_FL_ENTRY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req |-> 32'(fl_entry) < FL_ENTRIES); // R12
   AST_FL_NOT_ALLONES: assert property (@(posedge clk) disable iff (!rst_n)
      fl_gnt |-> aw_id != '1); // R3
   AST_UC_ALLONES: assert property (@(posedge clk) disable iff (!rst_n)
      uc_gnt |-> &aw_id); // R4
   AST_WB_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wb_gnt |-> !aw_id[ID_W-1]); // R2

endmodule

// File: tb/tb_awtag_wr_id_mux.sv
module tb_awtag_wr_id_mux;

   localparam int ID_W = 4;
   localparam int AW   = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wb_req = 0, fl_req = 0, uc_req = 0;
   logic [2:0]    wb_entry = '0, fl_entry = '0;
   logic [AW-1:0] wb_addr = '0, fl_addr = '0, uc_addr = '0;
   logic          wb_gnt, fl_gnt, uc_gnt;
   logic          aw_valid, aw_ready = 1'b0;
   logic [3:0]    aw_id;
   logic [AW-1:0] aw_addr;
   logic          b_valid = 1'b0;
   logic [3:0]    b_id = '0;
   logic          wb_b_valid, fl_b_valid, uc_b_valid;
   logic [2:0]    b_entry;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   awtag_wr_id_mux dut (
      .clk(clk), .rst_n(rst_n),
      .wb_req(wb_req), .wb_entry(wb_entry), .wb_addr(wb_addr), .wb_gnt(wb_gnt),
      .fl_req(fl_req), .fl_entry(fl_entry), .fl_addr(fl_addr), .fl_gnt(fl_gnt),
      .uc_req(uc_req), .uc_addr(uc_addr), .uc_gnt(uc_gnt),
      .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_addr(aw_addr),
      .b_valid(b_valid), .b_id(b_id),
      .wb_b_valid(wb_b_valid), .fl_b_valid(fl_b_valid), .uc_b_valid(uc_b_valid),
      .b_entry(b_entry)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic step;
      @(negedge clk);
      #1;
   endtask

   task automatic idle;
      wb_req = 0; fl_req = 0; uc_req = 0; aw_ready = 0; b_valid = 0;
   endtask

   task automatic t_reset;
      #1;
      chk(aw_valid == 0, "R1 aw_valid", aw_valid, 0);
      chk({wb_gnt, fl_gnt, uc_gnt} == 0, "R1 grants", {wb_gnt, fl_gnt, uc_gnt}, 0);
      chk({wb_b_valid, fl_b_valid, uc_b_valid} == 0, "R1 b strobes",
          {wb_b_valid, fl_b_valid, uc_b_valid}, 0);
   endtask

   task automatic t_ids;
      wb_req = 1; wb_entry = 3'd5; wb_addr = 32'h1000_0040; aw_ready = 1; #1;
      chk(aw_id == 4'b0101, "R2 wb id", aw_id, 4'b0101);
      chk(aw_addr == 32'h1000_0040 && wb_gnt, "R5 wb addr/gnt", aw_addr, 32'h1000_0040);
      step; idle;
      fl_req = 1; fl_entry = 3'd6; fl_addr = 32'h2000_0080; aw_ready = 1; #1;
      chk(aw_id == 4'b1110, "R3 fl id", aw_id, 4'b1110);
      chk(aw_addr == 32'h2000_0080 && fl_gnt, "R5 fl addr/gnt", aw_addr, 32'h2000_0080);
      step; idle;
      uc_req = 1; uc_addr = 32'h3000_00C0; aw_ready = 1; #1;
      chk(aw_id == 4'b1111, "R4 uc id", aw_id, 4'b1111);
      chk(aw_addr == 32'h3000_00C0 && uc_gnt, "R5 uc addr/gnt", aw_addr, 32'h3000_00C0);
      step; idle;
   endtask

   task automatic t_rr;
      wb_req = 1; fl_req = 1; uc_req = 1; aw_ready = 1; #1;
      chk(wb_gnt && !fl_gnt && !uc_gnt, "R6 rr first wb", {wb_gnt, fl_gnt, uc_gnt}, 3'b100);
      step; wb_req = 0; #1;
      chk(fl_gnt && !uc_gnt, "R6 rr second fl", {wb_gnt, fl_gnt, uc_gnt}, 3'b010);
      step; fl_req = 0; #1;
      chk(uc_gnt, "R6 rr third uc", {wb_gnt, fl_gnt, uc_gnt}, 3'b001);
      step; idle;
      fl_req = 1; aw_ready = 1; step; idle;
      wb_req = 1; uc_req = 1; aw_ready = 1; #1;
      chk(uc_gnt && !wb_gnt, "R6 after fl uc wins", {wb_gnt, fl_gnt, uc_gnt}, 3'b001);
      step; idle;
   endtask

   task automatic t_hold;
      wb_req = 1; aw_ready = 1; step; idle;
      uc_req = 1; aw_ready = 0; #1;
      chk(aw_valid && aw_id == 4'b1111 && !uc_gnt, "R7 stalled uc", aw_id, 4'b1111);
      step;
      fl_req = 1; fl_entry = 3'd2; #1;
      chk(aw_id == 4'b1111 && !fl_gnt, "R7 hold against fl", aw_id, 4'b1111);
      step;
      aw_ready = 1; #1;
      chk(uc_gnt && !fl_gnt, "R7 uc completes", {fl_gnt, uc_gnt}, 2'b01);
      step; uc_req = 0; #1;
      chk(fl_gnt && aw_id == 4'b1010, "R7 fl afterwards", aw_id, 4'b1010);
      step; idle;
   endtask

   task automatic t_b;
      b_valid = 1; b_id = 4'b0011; #1;
      chk(wb_b_valid && !fl_b_valid && !uc_b_valid && b_entry == 3, "R8 wb route",
          {wb_b_valid, fl_b_valid, uc_b_valid, b_entry}, {3'b100, 3'd3});
      b_id = 4'b1111; #1;
      chk(uc_b_valid && !wb_b_valid && !fl_b_valid, "R9 uc route",
          {wb_b_valid, fl_b_valid, uc_b_valid}, 3'b001);
      b_id = 4'b1010; #1;
      chk(fl_b_valid && !wb_b_valid && !uc_b_valid && b_entry == 2, "R10 fl route",
          {wb_b_valid, fl_b_valid, uc_b_valid, b_entry}, {3'b010, 3'd2});
      b_id = 4'b1110; #1;
      chk(fl_b_valid && !uc_b_valid && b_entry == 6, "R12 last flush entry",
          {fl_b_valid, uc_b_valid, b_entry}, {2'b10, 3'd6});
      b_valid = 0; #1;
      chk({wb_b_valid, fl_b_valid, uc_b_valid} == 0, "R11 idle b",
          {wb_b_valid, fl_b_valid, uc_b_valid}, 0);
      step;
   endtask

   task automatic t_overlap;
      fl_req = 1; fl_entry = 3'd4; fl_addr = 32'h2000_0100; aw_ready = 1;
      b_valid = 1; b_id = 4'b0000; #1;
      chk(fl_gnt && aw_id == 4'b1100, "R11 aw side in overlap", aw_id, 4'b1100);
      chk(wb_b_valid && !fl_b_valid && b_entry == 0, "R11 b side in overlap",
          {wb_b_valid, fl_b_valid, b_entry}, {2'b10, 3'd0});
      step; idle;
   endtask

   initial begin
      #80000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step;
      t_reset;
      t_ids;
      t_rr;
      t_hold;
      t_b;
      t_overlap;
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule